// File: doc/BRIEF.md
# Parallel-Input Serializer with Change Trigger

This block is the slave end of a four-wire serial link. It turns a parallel word into a serial frame of 4 to 16 bits. The word comes from one of two sources. The first is a register that captures the parallel input pins on every system clock edge. The second is an alternate word written by the host over a small register bus. An external master owns the serial clock and the chip select, and the block never starts a frame by itself. The serial clock and chip select are brought into the system clock domain through two-flop synchronizers. The system clock must run at least four times faster than the serial clock.

When a frame completes, the block keeps a copy of the word it sent in a comparison register. The host can read that copy back. The copy also feeds a trigger output that can start the next device in a chain. The trigger is raised when change detection is enabled and the selected source word no longer matches the copy. It is also raised when the hardware trigger input is high and its enable bit is set.

The engine runs three states. In IDLE the serial output is not driven. IDLE goes to SHIFT when the synchronized chip select becomes active, and the source word is loaded on that transition. SHIFT goes to DONE when the sample edge for the last bit arrives. SHIFT goes back to IDLE if chip select is released before then, which aborts the frame. DONE goes to IDLE when chip select is released, and that transition writes the comparison register.

Top module: `pin_serializer`

## Requirements
- R1: A frame loaded with a word of N bits presents bit N-1 first and bit 0 last on `sdo`, one bit per serial clock cycle. The block only shifts while the master holds `cs_n` low.
- R2: Control bit 4 selects the source word. A value of 0 selects the pin sample register, which captures `pins_in` on every clock edge and reads back at address 3. A value of 1 selects the alternate word at address 1.
- R3: Control bits [3:0] hold the frame length minus one. Field values 0, 1 and 2 give a 4-bit frame. Only the low N bits of the source word are sent and compared.
- R4: Control bit 7 sets the serial clock idle level and control bit 8 sets the phase. With phase 0, data is valid before the leading edge and changes after the trailing edge. With phase 1, data changes after the leading edge and is valid at the trailing edge.
- R5: When `cs_n` rises after a complete frame, the comparison register (address 2, read-only) takes the word that was sent.
- R6: With control bit 5 set, `trig_out` is 1 while the selected source word, limited to N bits, differs from the comparison register, and 0 while it matches.
- R7: If `cs_n` rises before all N bits have been clocked, the comparison register keeps its previous value.
- R8: While no frame is in progress, `sdo_en` and `sdo` are 0. `sdo_en` is 1 from frame start until `cs_n` is released.
- R9: With control bit 6 set, a high `hw_trig` drives `trig_out` to 1. With that bit clear and control bit 5 clear, `hw_trig` has no effect.
- R10: After reset, the control word, the alternate word and the comparison register read 0, and `trig_out`, `sdo` and `sdo_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | 16 | Parallel input pins |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select from the master |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for the serial data pad |
| hw_trig | input | 1 | Hardware trigger request |
| trig_out | output | 1 | Chaining trigger |
| bus_addr | input | 2 | Register address: 0 control, 1 alternate, 2 compare, 3 pins |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the register at `bus_addr` |

## Verification
The bench builds the block with its default width of 16 bits and a minimum frame of 4 bits. This covers frames from the clamped 4-bit minimum up to the full 16-bit word. Each vector sets a different source, idle level, phase and length, so all four clock modes and both data sources are run. The abort case and the hardware-trigger case are driven directly after the table.

// File: rtl/ps_pkg.sv
package ps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } ps_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_ALT  = 2'd1;
    localparam logic [1:0] ADDR_CMP  = 2'd2;
    localparam logic [1:0] ADDR_PINS = 2'd3;

    localparam int CTRL_W     = 9;
    localparam int BIT_SRC    = 4;
    localparam int BIT_CHG_EN = 5;
    localparam int BIT_HW_EN  = 6;
    localparam int BIT_CPOL   = 7;
    localparam int BIT_CPHA   = 8;
endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level
);
    logic stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            level  <= RST_VAL;
        end else begin
            stage1 <= async_in;
            level  <= stage1;
        end
    end
endmodule

// File: rtl/ps_regs.sv
module ps_regs
    import ps_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MIN_W  = 4,
    localparam int LEN_W = $clog2(DATA_W),
    localparam int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wen,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pins_in,
    input  logic              hw_trig,
    input  logic              commit,
    input  logic [DATA_W-1:0] sent_word,
    output logic [CNT_W-1:0]  flen,
    output logic              cpol,
    output logic              cpha,
    output logic              hw_en,
    output logic [DATA_W-1:0] load_word,
    output logic [DATA_W-1:0] cmp_q,
    output logic              trig_out
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] alt_q;
    logic [DATA_W-1:0] pins_q;
    logic [LEN_W-1:0]  len_field;
    logic [DATA_W-1:0] len_mask;
    logic              chg_en;

    assign len_field = ctrl_q[LEN_W-1:0];
    assign flen      = ({1'b0, len_field} < CNT_W'(MIN_W - 1)) ? CNT_W'(MIN_W)
                                                            : {1'b0, len_field} + CNT_W'(1);
    assign cpol      = ctrl_q[BIT_CPOL];
    assign cpha      = ctrl_q[BIT_CPHA];
    assign hw_en     = ctrl_q[BIT_HW_EN];
    assign chg_en    = ctrl_q[BIT_CHG_EN];
    assign len_mask  = ~({DATA_W{1'b1}} << flen);
    assign load_word = (ctrl_q[BIT_SRC] ? alt_q : pins_q) & len_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            alt_q    <= '0;
            pins_q   <= '0;
            cmp_q    <= '0;
            trig_out <= 1'b0;
        end else begin
            pins_q <= pins_in;
            if (bus_wen && bus_addr == ADDR_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (bus_wen && bus_addr == ADDR_ALT)  alt_q  <= bus_wdata;
            if (commit) cmp_q <= sent_word;
            trig_out <= (chg_en && (load_word != cmp_q)) || (hw_en && hw_trig);
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = DATA_W'(ctrl_q);
            ADDR_ALT:  bus_rdata = alt_q;
            ADDR_CMP:  bus_rdata = cmp_q;
            default:   bus_rdata = pins_q;
        endcase
    end
endmodule

// File: rtl/ps_engine.sv
module ps_engine
    import ps_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int LEN_W = $clog2(DATA_W),
    localparam int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_lvl,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [CNT_W-1:0]  flen,
    input  logic [DATA_W-1:0] load_word,
    output logic              sdo,
    output logic              sdo_en,
    output logic              commit,
    output logic [DATA_W-1:0] sent_word,
    output ps_state_e         state
);
    ps_state_e         next_state;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic              first_edge;
    logic              sclk_prev;
    logic              edge_seen;
    logic              lead_edge;
    logic              trail_edge;
    logic              sample_edge;
    logic              shift_edge;
    logic              last_bit;

    assign edge_seen   = (sclk_lvl != sclk_prev);
    assign lead_edge   = edge_seen && (sclk_lvl != cpol);
    assign trail_edge  = edge_seen && (sclk_lvl == cpol);
    assign sample_edge = cpha ? trail_edge : lead_edge;
    assign shift_edge  = cpha ? lead_edge : trail_edge;
    assign last_bit    = (bit_cnt + CNT_W'(1)) == flen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        sdo_en     = 1'b0;
        commit     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cs_act) next_state = ST_SHIFT;
            end
            ST_SHIFT: begin
                sdo_en = 1'b1;
                if (!cs_act)                      next_state = ST_IDLE;
                else if (sample_edge && last_bit) next_state = ST_DONE;
            end
            ST_DONE: begin
                sdo_en = 1'b1;
                if (!cs_act) begin
                    commit     = 1'b1;
                    next_state = ST_IDLE;
                end
            end
            default: next_state = ST_IDLE;
        endcase
    end

    assign sdo = sdo_en & shreg[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            sent_word  <= '0;
            bit_cnt    <= '0;
            first_edge <= 1'b0;
            sclk_prev  <= 1'b0;
        end else begin
            sclk_prev <= sclk_lvl;
            if (state == ST_IDLE) begin
                if (cs_act) begin
                    shreg      <= load_word << (CNT_W'(DATA_W) - flen);
                    sent_word  <= load_word;
                    bit_cnt    <= '0;
                    first_edge <= 1'b1;
                end
            end else if (state == ST_SHIFT) begin
                if (shift_edge) begin
                    first_edge <= 1'b0;
                    if (!(cpha && first_edge)) shreg <= shreg << 1;
                end
                if (sample_edge) bit_cnt <= bit_cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/pin_serializer.sv
module pin_serializer
    import ps_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MIN_W  = 4,
    localparam int LEN_W = $clog2(DATA_W),
    localparam int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pins_in,
    input  logic              sclk,
    input  logic              cs_n,
    output logic              sdo,
    output logic              sdo_en,
    input  logic              hw_trig,
    output logic              trig_out,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wen,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              sclk_lvl;
    logic              cs_lvl;
    logic [CNT_W-1:0]  flen_w;
    logic              cpol_w;
    logic              cpha_w;
    logic              hw_en_w;
    logic [DATA_W-1:0] load_w;
    logic [DATA_W-1:0] cmp_w;
    logic [DATA_W-1:0] sent_w;
    logic              commit_w;
    ps_state_e         state_w;

    ps_sync #(.RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .async_in(sclk), .level(sclk_lvl)
    );

    ps_sync #(.RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .async_in(cs_n), .level(cs_lvl)
    );

    ps_regs #(.DATA_W(DATA_W), .MIN_W(MIN_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins_in(pins_in), .hw_trig(hw_trig), .commit(commit_w), .sent_word(sent_w),
        .flen(flen_w), .cpol(cpol_w), .cpha(cpha_w), .hw_en(hw_en_w),
        .load_word(load_w), .cmp_q(cmp_w), .trig_out(trig_out)
    );

    ps_engine #(.DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .cs_act(!cs_lvl), .sclk_lvl(sclk_lvl),
        .cpol(cpol_w), .cpha(cpha_w), .flen(flen_w), .load_word(load_w),
        .sdo(sdo), .sdo_en(sdo_en), .commit(commit_w), .sent_word(sent_w),
        .state(state_w)
    );
endmodule

// File: rtl/pin_serializer_chk.sv
module pin_serializer_chk
    import ps_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input ps_state_e         state,
    input logic [DATA_W-1:0] cmp,
    input logic              hw_en,
    input logic              hw_trig,
    input logic              trig_out
);
    p_cmp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp) |-> $past(state) == ST_DONE);

    p_hw_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_en && hw_trig) |=> trig_out);

    p_done_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_DONE && state != ST_DONE) |-> state == ST_IDLE);

    p_shift_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && $past(state) != ST_SHIFT) |-> $past(state) == ST_IDLE);
endmodule

bind pin_serializer pin_serializer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_w), .cmp(cmp_w),
    .hw_en(hw_en_w), .hw_trig(hw_trig), .trig_out(trig_out)
);

// File: tb/pin_serializer_bench.sv
module pin_serializer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;
    localparam int NVEC = 6;
    // {src, cpol, cpha, len[4:0], pins[15:0], alt[15:0]}
    localparam logic [39:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 5'd8,  16'h00A5, 16'h1234},
        {1'b1, 1'b0, 1'b1, 5'd16, 16'h0F0F, 16'hBEEF},
        {1'b0, 1'b1, 1'b0, 5'd4,  16'hFFF9, 16'h0000},
        {1'b1, 1'b1, 1'b1, 5'd12, 16'h0000, 16'hF123},
        {1'b0, 1'b0, 1'b1, 5'd5,  16'h0015, 16'hFFFF},
        {1'b1, 1'b1, 1'b0, 5'd16, 16'h1234, 16'h8001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins_in = '0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdo, sdo_en, trig_out;
    logic        hw_trig = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_serializer u_pin_serializer (
        .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .sclk(sclk), .cs_n(cs_n),
        .sdo(sdo), .sdo_en(sdo_en), .hw_trig(hw_trig), .trig_out(trig_out),
        .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // Master: clock nbits of a frame, then release chip select.
    task automatic frame(input logic cpol, input logic cpha, input int nbits,
                         output logic [15:0] rx, output logic en_mid);
        rx = '0;
        en_mid = 1'b0;
        sclk = cpol;
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
        en_mid = sdo_en;
        for (int i = 0; i < nbits; i++) begin
            if (!cpha) rx = {rx[14:0], sdo};
            sclk = ~cpol;
            wait_clk(HALF);
            if (cpha) rx = {rx[14:0], sdo};
            sclk = cpol;
            wait_clk(HALF);
        end
        cs_n = 1'b1;
        wait_clk(HALF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rx, rv, word, mask;
        logic        en_mid;
        logic        src, cpol, cpha;
        int          len;

        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        // R10 reset state
        rd(2'd0, rv); chk("R10 ctrl", rv, 16'h0000);
        rd(2'd1, rv); chk("R10 alt", rv, 16'h0000);
        rd(2'd2, rv); chk("R10 cmp", rv, 16'h0000);
        chk("R10 outputs", {13'd0, trig_out, sdo, sdo_en}, 16'h0000);

        for (int v = 0; v < NVEC; v++) begin
            src  = VEC[v][39];
            cpol = VEC[v][38];
            cpha = VEC[v][37];
            len  = int'(VEC[v][36:32]);
            pins_in = VEC[v][31:16];
            wr(2'd1, VEC[v][15:0]);
            sclk = cpol;
            wr(2'd0, {7'd0, cpha, cpol, 1'b0, 1'b1, src, 4'(len - 1)});
            mask = (len == 16) ? 16'hFFFF : 16'((1 << len) - 1);
            word = (src ? VEC[v][15:0] : VEC[v][31:16]) & mask;
            wait_clk(4);
            rd(2'd3, rv); chk("R2 pin sample readback", rv, VEC[v][31:16]);
            frame(cpol, cpha, len, rx, en_mid);
            chk("R1 R2 R4 received frame", rx, word);
            chk("R8 enable mid-frame", {15'd0, en_mid}, 16'h0001);
            chk("R8 idle after frame", {14'd0, sdo_en, sdo}, 16'h0000);
            rd(2'd2, rv); chk("R5 compare copy", rv, word);
            wait_clk(3);
            chk("R6 trigger low on match", {15'd0, trig_out}, 16'h0000);
            if (src) wr(2'd1, VEC[v][15:0] ^ 16'h0001);
            else     pins_in = VEC[v][31:16] ^ 16'h0001;
            wait_clk(4);
            chk("R6 trigger high on change", {15'd0, trig_out}, 16'h0001);
        end

        // R3 length clamp: field 1 gives a 4-bit frame
        pins_in = 16'hFFFA;
        sclk = 1'b0;
        wr(2'd0, 16'h0001);
        wait_clk(4);
        frame(1'b0, 1'b0, 4, rx, en_mid);
        chk("R3 clamped frame", rx, 16'h000A);
        rd(2'd2, rv); chk("R3 clamped compare", rv, 16'h000A);

        // R7 aborted frame leaves compare unchanged
        pins_in = 16'h0003;
        wr(2'd0, 16'h0007);
        wait_clk(4);
        frame(1'b0, 1'b0, 3, rx, en_mid);
        rd(2'd2, rv); chk("R7 compare after abort", rv, 16'h000A);
        chk("R8 idle after abort", {14'd0, sdo_en, sdo}, 16'h0000);

        // R9 hardware trigger
        wr(2'd0, 16'h0047);
        hw_trig = 1'b1;
        wait_clk(3);
        chk("R9 hw trigger enabled", {15'd0, trig_out}, 16'h0001);
        wr(2'd0, 16'h0007);
        wait_clk(3);
        chk("R9 hw trigger disabled", {15'd0, trig_out}, 16'h0000);
        hw_trig = 1'b0;
        wait_clk(3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule